// File: doc/BRIEF.md
# Predicated Set-First Mask Generator

This block turns an N-bit source mask into an N-bit destination mask by scanning the elements from bit 0 upward. Three shaping modes are offered. Set-before-first marks every active element ahead of the first active source 1. Set-including-first also marks that element. Set-only-first marks that element alone. An optional predicate selects which elements are active. Inactive elements are skipped, and their destination bits are cleared.

The scan is modelled as a per-element state machine with three states. `ST_SET` means the scan is still hunting for a 1 and is writing the mode's "before" value. `ST_DONE` means a 1 has been found, and the scan writes 0. `ST_GAP` means the previous element was predicated out.

The transitions work as follows:
- `found`: SET or GAP moves to DONE at an active element whose source bit is 1.
- `resume`: GAP moves to SET at an active element whose source bit is 0.
- `gap`: any state moves to GAP at an inactive element.
- `stay`: SET stays SET on an active 0, and DONE stays DONE on an active element.

The scan starts in SET when the predicate is off or predicate bit 0 is set, and in GAP otherwise. Because of the gap and resume transitions, each contiguous run of active elements is shaped on its own. The combinational scan result is captured in an output register whenever the input strobe is high.

Top module: `sfm_setfirst`

## Requirements
- R1: With mode code 0 (set-before-first), active elements below the first active source 1 read 1; that element and all later active elements of the same run read 0.
- R2: With mode 0 or 1 and no active source 1, every active destination bit reads 1; with mode 2 it reads all 0.
- R3: With mode code 1 (set-including-first), the result equals set-before-first with the element holding the first active 1 also set.
- R4: With mode code 2 (set-only-first), only the first active element of a run whose source bit is 1 reads 1; with the predicate off the result has at most one bit set.
- R5: Every destination bit whose predicate bit is 0 reads 0 while the predicate is enabled.
- R6: After one or more predicated-out elements, the next active element restarts the scan in setting mode, so each run of active elements is shaped independently.
- R7: A source 1 at a predicated-out position has no effect on any destination bit.
- R8: `valid_o` is high exactly in the cycle after `valid_i` was high; `dst_o` changes only on a cycle following a high `valid_i`.
- R9: After reset, `valid_o` is 0 and `dst_o` is all 0.
- R10: Mode code 3 is reserved and yields an all-zero result.
- R11: With `pred_en_i` low, `pred_i` is ignored and all elements are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input strobe; captures a new result |
| src_i | input | N | Source mask, bit 0 scanned first |
| pred_i | input | N | Predicate; 1 marks an active element |
| pred_en_i | input | 1 | 1 applies `pred_i`, 0 makes all elements active |
| mode_i | input | 2 | 0 before-first, 1 including-first, 2 only-first, 3 reserved |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| dst_o | output | N | Registered destination mask |

## Verification
The hardest situation to reach is the `resume` transition after a `found` transition. Here a scan that has already found its 1 must forget it across a predicated-out gap and start setting again in the next run. Plain unpredicated patterns never leave the DONE state.

The stimulus reaches this case with predicates that split the vector into two or more runs, with source 1s placed before, inside and after the gaps. It also places a lone source 1 under a cleared predicate bit to show that the bit is ignored.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    typedef enum logic [1:0] {
        MODE_BEFORE = 2'd0,
        MODE_INCL   = 2'd1,
        MODE_ONLY   = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_SET  = 2'd0,
        ST_DONE = 2'd1,
        ST_GAP  = 2'd2
    } scan_e;
endpackage

// File: rtl/sfm_cell.sv
module sfm_cell
    import sfm_pkg::*;
(
    input  scan_e state_i,
    input  logic  act_i,
    input  logic  src_i,
    input  mode_e mode_i,
    output logic  dst_o,
    output scan_e state_o
);
    logic hit_val;
    logic miss_val;

    // Value written at the first active 1 and at active 0s before it.
    always_comb begin
        hit_val  = 1'b0;
        miss_val = 1'b0;
        unique case (mode_i)
            MODE_BEFORE: begin hit_val = 1'b0; miss_val = 1'b1; end
            MODE_INCL:   begin hit_val = 1'b1; miss_val = 1'b1; end
            MODE_ONLY:   begin hit_val = 1'b1; miss_val = 1'b0; end
            MODE_RSVD:   begin hit_val = 1'b0; miss_val = 1'b0; end
        endcase
    end

    // Next-state and output of one element of the scan.
    always_comb begin
        dst_o   = 1'b0;
        state_o = state_i;
        if (!act_i) begin
            state_o = ST_GAP;          // gap
        end else begin
            unique case (state_i)
                ST_SET, ST_GAP: begin
                    if (src_i) begin
                        dst_o   = hit_val;
                        state_o = ST_DONE; // found
                    end else begin
                        dst_o   = miss_val;
                        state_o = ST_SET;  // stay / resume
                    end
                end
                ST_DONE: begin
                    dst_o   = 1'b0;
                    state_o = ST_DONE;     // stay
                end
                default: begin
                    dst_o   = 1'b0;
                    state_o = ST_DONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sfm_chain.sv
module sfm_chain
    import sfm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] act_i,
    input  logic         pred_en_i,
    input  mode_e        mode_i,
    output logic [N-1:0] dst_o
);
    scan_e st [N+1];

    // Starts setting unless the predicate is in use and bit 0 is off.
    assign st[0] = (!pred_en_i || act_i[0]) ? ST_SET : ST_GAP;

    for (genvar g = 0; g < N; g++) begin : g_elem
        sfm_cell u_cell (
            .state_i (st[g]),
            .act_i   (act_i[g]),
            .src_i   (src_i[g]),
            .mode_i  (mode_i),
            .dst_o   (dst_o[g]),
            .state_o (st[g+1])
        );
    end
endmodule

// File: rtl/sfm_setfirst.sv
module sfm_setfirst
    import sfm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pred_i,
    input  logic         pred_en_i,
    input  logic [1:0]   mode_i,
    output logic         valid_o,
    output logic [N-1:0] dst_o
);
    localparam logic [N-1:0] ALL_ON = {N{1'b1}};

    logic [N-1:0] act;
    logic [N-1:0] scan_dst;
    mode_e        mode;

    assign act  = pred_en_i ? pred_i : ALL_ON;
    assign mode = mode_e'(mode_i);

    sfm_chain #(.N(N)) u_chain (
        .src_i     (src_i),
        .act_i     (act),
        .pred_en_i (pred_en_i),
        .mode_i    (mode),
        .dst_o     (scan_dst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            dst_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                dst_o <= scan_dst;
            end
        end
    end

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(dst_o));
    p_inactive_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_en_i) |=> ((dst_o & ~$past(pred_i)) == '0));
    p_only_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !pred_en_i && mode_i == 2'd2) |=> $onehot0(dst_o));
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i == 2'd3) |=> (dst_o == '0));
endmodule

// File: tb/sfm_setfirst_tb_top.sv
`timescale 1ns/1ps
module sfm_setfirst_tb_top;
    localparam int N  = 8;
    localparam int NV = 18;

    typedef struct packed {
        logic [1:0] mode;
        logic       pe;
        logic [7:0] pred;
        logic [7:0] src;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 8'h00, 8'b10010100, 8'b00000011, 4'd1},  // R1
        '{2'd1, 1'b0, 8'h00, 8'b10010100, 8'b00000111, 4'd3},  // R3
        '{2'd2, 1'b0, 8'h00, 8'b10010100, 8'b00000100, 4'd4},  // R4
        '{2'd0, 1'b0, 8'h00, 8'b00000000, 8'b11111111, 4'd2},  // R2
        '{2'd1, 1'b0, 8'h00, 8'b00000000, 8'b11111111, 4'd2},  // R2
        '{2'd2, 1'b0, 8'h00, 8'b00000000, 8'b00000000, 4'd2},  // R2
        '{2'd0, 1'b1, 8'b11000011, 8'b10010100, 8'b01000011, 4'd6},  // R6
        '{2'd2, 1'b1, 8'b11000011, 8'b11010100, 8'b01000000, 4'd6},  // R6
        '{2'd1, 1'b1, 8'b11000011, 8'b10010100, 8'b11000011, 4'd6},  // R6
        '{2'd2, 1'b1, 8'b11110111, 8'b00100010, 8'b00100010, 4'd6},  // R6
        '{2'd0, 1'b1, 8'b00000000, 8'b11111111, 8'b00000000, 4'd5},  // R5
        '{2'd0, 1'b1, 8'b11111110, 8'b00000001, 8'b11111110, 4'd7},  // R7
        '{2'd2, 1'b1, 8'b11011111, 8'b00100000, 8'b00000000, 4'd7},  // R7
        '{2'd0, 1'b0, 8'h00, 8'b00000000, 8'b11111111, 4'd11}, // R11
        '{2'd3, 1'b0, 8'h00, 8'b10010100, 8'b00000000, 4'd10}, // R10
        '{2'd0, 1'b0, 8'h00, 8'b00000001, 8'b00000000, 4'd1},  // R1
        '{2'd1, 1'b0, 8'h00, 8'b10000000, 8'b11111111, 4'd3},  // R3
        '{2'd0, 1'b0, 8'h00, 8'b10000000, 8'b01111111, 4'd1}   // R1
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [N-1:0] src_i = '0;
    logic [N-1:0] pred_i = '0;
    logic         pred_en_i = 1'b0;
    logic [1:0]   mode_i = '0;
    logic         valid_o;
    logic [N-1:0] dst_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sfm_setfirst #(.N(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .src_i     (src_i),
        .pred_i    (pred_i),
        .pred_en_i (pred_en_i),
        .mode_i    (mode_i),
        .valid_o   (valid_o),
        .dst_o     (dst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        mode_i    = v.mode;
        pred_en_i = v.pe;
        pred_i    = v.pred;
        src_i     = v.src;
        valid_i   = 1'b1;
        @(negedge clk);
        valid_i   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 valid_o", {31'd0, valid_o}, 32'd0);
        check("R9 dst_o", {24'd0, dst_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check($sformatf("R%0d vec%0d", TBL[i].req, i), {24'd0, dst_o}, {24'd0, TBL[i].exp});
            check("R8 valid_o after valid_i", {31'd0, valid_o}, 32'd1);
        end

        // R8: inputs change with valid_i low; result must hold and valid_o stay low.
        apply('{2'd0, 1'b0, 8'h00, 8'b00010000, 8'b00001111, 4'd1});
        check("R1 before hold", {24'd0, dst_o}, 32'h0f);
        src_i = 8'h00; mode_i = 2'd1; pred_en_i = 1'b1; pred_i = 8'hff;
        repeat (3) @(negedge clk);
        check("R8 hold dst_o", {24'd0, dst_o}, 32'h0f);
        check("R8 idle valid_o", {31'd0, valid_o}, 32'd0);

        // R11: predicate content irrelevant when disabled.
        apply('{2'd2, 1'b0, 8'b00000000, 8'b01000000, 8'b01000000, 4'd11});
        check("R11 pred ignored", {24'd0, dst_o}, 32'h40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule